// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port Controller

An eight-pin general-purpose port that a processor drives over a small byte-wide register bus. A 2-bit mode field sets each pin on its own. In one mode the pin is a push-pull output driven from an output latch. The other three modes are inputs, and each of them fixes which edge of the pin raises an interrupt and whether the pad pull-up is switched on.

Every input pin passes through a two-flop synchroniser. Edges are found by comparing the synchronised level with the sample from the cycle before. When a pin's interrupt-enable bit is set and its selected edge arrives, hardware sets that pin's pending bit. Software clears a pending bit by writing 0 to it. A single active-low request line stays low while any pending bit is set. Reads of the data register return the synchronised pin levels.

Register map (bus addresses): data `0xE2`, control for pins 0..3 `0xE6`, control for pins 4..7 `0xE7`, interrupt enable `0xEC`, interrupt pending `0xED`. Any other address reads as 0.

Top module: `gpio_edge_irq_port`

## Requirements
- R1: After reset, both control registers, the enable register and the pending register read 0x00. Every pin is an input (pin_oe = 0), no pull-up is on (pin_pu = 0), and irq_n is 1.
- R2: A write to 0xE2 loads the output latch, which appears on pin_out. A read of 0xE2 returns pin_in as sampled through the two-flop synchroniser.
- R3: Pin i (i = 0..3) takes its mode from bits [2i+1:2i] of register 0xE6. Pin i (i = 4..7) takes its mode from bits [2(i-4)+1:2(i-4)] of register 0xE7. Mode 11 sets pin_oe[i]. Mode 10 sets pin_pu[i]. The two are never both set on one pin.
- R4: Mode 00 is an input that sets pending on a falling edge and ignores rising edges.
- R5: Mode 01 is an input that sets pending on a rising edge and ignores falling edges.
- R6: Mode 10 is an input with pull-up that sets pending on a falling edge and ignores rising edges.
- R7: An edge on a pin whose enable bit (register 0xEC, bit i = pin i) is 0 leaves its pending bit unchanged.
- R8: A pin in mode 11 never sets its pending bit, whatever its input does.
- R9: irq_n is 0 exactly while at least one pending bit (register 0xED, bit i = pin i) is 1.
- R10: Writing 0 to a pending bit clears it. Writing 1 leaves it unchanged.
- R11: When a qualifying edge and a software clear of the same pending bit land in the same cycle, the bit ends up 1.
- R12: The control, enable and pending registers read back their current contents, and unmapped addresses read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from bus_addr) |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Output latch value |
| pin_oe | output | 8 | Output enable per pin |
| pin_pu | output | 8 | Pull-up enable per pin |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The bench goes after the edge-polarity decode of each input mode by driving both edge directions on the same pin. A design with a swapped or missing polarity would set pending on the ignored edge, or miss the wanted one. It lands a software clear in the exact cycle a new edge is detected. A design where the clear takes priority would lose that interrupt and leave irq_n high. It also checks that writing ones to the pending register keeps other bits set, that output-mode and disabled pins stay silent, and that the split control registers map to the right pins. A wrong nibble or bit order shows up as the wrong pin_oe or pin_pu bit.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned NPINS = 8;
  localparam int unsigned PINS_PER_CTRL = 4;

  typedef enum logic [1:0] {
    MODE_IN_FALL      = 2'b00,
    MODE_IN_RISE      = 2'b01,
    MODE_IN_PULL_FALL = 2'b10,
    MODE_OUT          = 2'b11
  } pin_mode_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/gpio_in_edge.sv
module gpio_in_edge #(
  parameter int unsigned NPINS       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] level_o,
  output logic [NPINS-1:0] rise_o,
  output logic [NPINS-1:0] fall_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] shift_q, shift_d;
    logic                   prev_q;

    always_comb begin
      shift_d = {shift_q[SYNC_STAGES-2:0], pin_i[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shift_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        shift_q <= shift_d;
        prev_q  <= shift_q[LAST];
      end
    end

    assign level_o[p] = shift_q[LAST];
    assign rise_o[p]  =  shift_q[LAST] & ~prev_q;
    assign fall_o[p]  = ~shift_q[LAST] &  prev_q;
  end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_edge_pkg::*;
#(
  parameter logic [7:0] ADDR_DATA    = 8'hE2,
  parameter logic [7:0] ADDR_CTRL_LO = 8'hE6,
  parameter logic [7:0] ADDR_CTRL_HI = 8'hE7,
  parameter logic [7:0] ADDR_IEN     = 8'hEC,
  parameter logic [7:0] ADDR_PEND    = 8'hED
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [7:0]                  bus_addr,
  input  logic [7:0]                  bus_wdata,
  output logic [7:0]                  bus_rdata,
  input  logic [NPINS-1:0]            level_i,
  input  logic [NPINS-1:0]            pend_i,
  output logic [NPINS-1:0]            out_o,
  output logic [NPINS-1:0]            ien_o,
  output pin_mode_e [NPINS-1:0]       mode_o,
  output logic [NPINS-1:0]            pend_clr_o
);
  logic [7:0] out_q, out_d;
  logic [7:0] ctl_lo_q, ctl_lo_d;
  logic [7:0] ctl_hi_q, ctl_hi_d;
  logic [7:0] ien_q, ien_d;
  logic       wr_en;

  assign wr_en = bus_sel & bus_we;

  always_comb begin
    out_d      = out_q;
    ctl_lo_d   = ctl_lo_q;
    ctl_hi_d   = ctl_hi_q;
    ien_d      = ien_q;
    pend_clr_o = '0;
    if (wr_en) begin
      unique case (bus_addr)
        ADDR_DATA:    out_d      = bus_wdata;
        ADDR_CTRL_LO: ctl_lo_d   = bus_wdata;
        ADDR_CTRL_HI: ctl_hi_d   = bus_wdata;
        ADDR_IEN:     ien_d      = bus_wdata;
        ADDR_PEND:    pend_clr_o = ~bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      ctl_lo_q <= '0;
      ctl_hi_q <= '0;
      ien_q    <= '0;
    end else begin
      out_q    <= out_d;
      ctl_lo_q <= ctl_lo_d;
      ctl_hi_q <= ctl_hi_d;
      ien_q    <= ien_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_DATA:    bus_rdata = level_i;
      ADDR_CTRL_LO: bus_rdata = ctl_lo_q;
      ADDR_CTRL_HI: bus_rdata = ctl_hi_q;
      ADDR_IEN:     bus_rdata = ien_q;
      ADDR_PEND:    bus_rdata = pend_i;
      default:      bus_rdata = 8'h00;
    endcase
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_mode
    if (p < PINS_PER_CTRL) begin : g_lo
      assign mode_o[p] = pin_mode_e'(ctl_lo_q[2*p +: 2]);
    end else begin : g_hi
      assign mode_o[p] = pin_mode_e'(ctl_hi_q[2*(p-PINS_PER_CTRL) +: 2]);
    end
  end

  assign out_o = out_q;
  assign ien_o = ien_q;
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend
  import gpio_edge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  pin_mode_e [NPINS-1:0] mode_i,
  input  logic [NPINS-1:0]      ien_i,
  input  logic [NPINS-1:0]      rise_i,
  input  logic [NPINS-1:0]      fall_i,
  input  logic [NPINS-1:0]      clr_i,
  output logic [NPINS-1:0]      pend_o
);
  logic [NPINS-1:0] pend_q, pend_d, hit;

  for (genvar p = 0; p < NPINS; p++) begin : g_hit
    always_comb begin
      unique case (mode_i[p])
        MODE_IN_FALL,
        MODE_IN_PULL_FALL: hit[p] = ien_i[p] & fall_i[p];
        MODE_IN_RISE:      hit[p] = ien_i[p] & rise_i[p];
        default:           hit[p] = 1'b0;
      endcase
    end
  end

  always_comb begin
    pend_d = hit | (pend_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_edge_irq_port.sv
module gpio_edge_irq_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [7:0]  ADDR_DATA    = 8'hE2,
  parameter logic [7:0]  ADDR_CTRL_LO = 8'hE6,
  parameter logic [7:0]  ADDR_CTRL_HI = 8'hE7,
  parameter logic [7:0]  ADDR_IEN     = 8'hEC,
  parameter logic [7:0]  ADDR_PEND    = 8'hED
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [7:0] pin_in,
  output logic [7:0] pin_out,
  output logic [7:0] pin_oe,
  output logic [7:0] pin_pu,
  output logic       irq_n
);
  logic                  rst_sync_n;
  logic [NPINS-1:0]      level_w, rise_w, fall_w;
  logic [NPINS-1:0]      ien_w, pend_w, clr_w;
  pin_mode_e [NPINS-1:0] mode_w;

  gpio_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_sync_n)
  );

  gpio_in_edge #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .pin_i   (pin_in),
    .level_o (level_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  gpio_regfile #(
    .ADDR_DATA(ADDR_DATA), .ADDR_CTRL_LO(ADDR_CTRL_LO), .ADDR_CTRL_HI(ADDR_CTRL_HI),
    .ADDR_IEN(ADDR_IEN), .ADDR_PEND(ADDR_PEND)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .level_i    (level_w),
    .pend_i     (pend_w),
    .out_o      (pin_out),
    .ien_o      (ien_w),
    .mode_o     (mode_w),
    .pend_clr_o (clr_w)
  );

  gpio_pend u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .mode_i (mode_w),
    .ien_i  (ien_w),
    .rise_i (rise_w),
    .fall_i (fall_w),
    .clr_i  (clr_w),
    .pend_o (pend_w)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pad
    assign pin_oe[p] = (mode_w[p] == MODE_OUT);
    assign pin_pu[p] = (mode_w[p] == MODE_IN_PULL_FALL);
  end

  assign irq_n = ~|pend_w;
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter logic [7:0] ADDR_PEND = 8'hED
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_we,
  input logic [7:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic [7:0]  pend,
  input logic [7:0]  ien,
  input logic [15:0] mode_flat,
  input logic [7:0]  pin_oe,
  input logic [7:0]  pin_pu,
  input logic        irq_n
);
  // R3: output and pull-up never on together
  p_oe_pu_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_pu) == 8'h00);

  // R9: any pending bit pulls the request low
  p_irq_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != 8'h00) |-> !irq_n);

  for (genvar p = 0; p < 8; p++) begin : g_bit
    // R7: a pending bit rises only if its enable was set
    p_set_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[p]) |-> $past(ien[p]));

    // R8: an output-mode pin never raises pending
    p_no_set_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[p]) |-> ($past(mode_flat[2*p +: 2]) != 2'b11));

    // R10: a pending bit falls only after a software write of 0 to it
    p_clear_by_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend[p]) |-> $past(bus_sel && bus_we && bus_addr == ADDR_PEND && !bus_wdata[p]));
  end
endmodule

bind gpio_edge_irq_port gpio_edge_irq_chk #(.ADDR_PEND(ADDR_PEND)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pend      (pend_w),
  .ien       (ien_w),
  .mode_flat (mode_w),
  .pin_oe    (pin_oe),
  .pin_pu    (pin_pu),
  .irq_n     (irq_n)
);

// File: tb/gpio_edge_irq_port_bench.sv
module gpio_edge_irq_port_bench;
  localparam time CLK_PERIOD = 4ns;
  localparam logic [7:0] A_DATA = 8'hE2, A_LO = 8'hE6, A_HI = 8'hE7,
                         A_IEN = 8'hEC, A_PEND = 8'hED;

  logic       clk = 1'b0;
  logic       arst_n;
  logic       bus_sel, bus_we;
  logic [7:0] bus_addr, bus_wdata, bus_rdata;
  logic [7:0] pin_in, pin_out, pin_oe, pin_pu;
  logic       irq_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_irq_port u_gpio_edge_irq_port (
    .clk(clk), .arst_n(arst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
    .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 8'h00; bus_wdata = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0; bus_addr = 8'h00;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic set_pins(input logic [7:0] v);
    pin_in = v;
    tick(3);
  endtask

  task automatic t_reset;
    check("R1 oe", pin_oe, 8'h00);
    check("R1 pu", pin_pu, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    expect_reg("R1 ctrl lo", A_LO, 8'h00);
    expect_reg("R1 ctrl hi", A_HI, 8'h00);
    expect_reg("R1 enable", A_IEN, 8'h00);
    expect_reg("R1 pending", A_PEND, 8'h00);
  endtask

  task automatic t_data;
    wr(A_DATA, 8'hA5);
    check("R2 pin_out", pin_out, 8'hA5);
    set_pins(8'h3C);
    expect_reg("R2 data read", A_DATA, 8'h3C);
    set_pins(8'hFF);
    expect_reg("R2 data read high", A_DATA, 8'hFF);
  endtask

  task automatic t_ctrl;
    wr(A_LO, 8'hE4);
    wr(A_HI, 8'h3B);
    check("R3 oe map", pin_oe, 8'h58);
    check("R3 pu map", pin_pu, 8'h24);
    expect_reg("R12 ctrl lo readback", A_LO, 8'hE4);
    expect_reg("R12 ctrl hi readback", A_HI, 8'h3B);
    expect_reg("R12 unmapped", 8'h00, 8'h00);
    wr(A_LO, 8'h00);
    wr(A_HI, 8'h00);
    check("R3 oe cleared", pin_oe, 8'h00);
  endtask

  task automatic t_fall_and_clear;
    wr(A_IEN, 8'h03);
    expect_reg("R12 enable readback", A_IEN, 8'h03);
    set_pins(8'hFC);
    expect_reg("R4 falling sets", A_PEND, 8'h03);
    check("R9 irq low", {7'd0, irq_n}, 8'h00);
    wr(A_PEND, 8'hFE);
    expect_reg("R10 clear bit0 keep bit1", A_PEND, 8'h02);
    check("R9 irq still low", {7'd0, irq_n}, 8'h00);
    wr(A_PEND, 8'h00);
    expect_reg("R10 clear all", A_PEND, 8'h00);
    check("R9 irq high", {7'd0, irq_n}, 8'h01);
    set_pins(8'hFF);
    expect_reg("R4 rising ignored", A_PEND, 8'h00);
  endtask

  task automatic t_rise;
    wr(A_LO, 8'h10);
    wr(A_IEN, 8'h04);
    set_pins(8'hFB);
    expect_reg("R5 falling ignored", A_PEND, 8'h00);
    set_pins(8'hFF);
    expect_reg("R5 rising sets", A_PEND, 8'h04);
    wr(A_PEND, 8'h00);
  endtask

  task automatic t_pullup;
    wr(A_LO, 8'h80);
    wr(A_IEN, 8'h08);
    check("R6 pull-up on", pin_pu, 8'h08);
    set_pins(8'hF7);
    expect_reg("R6 falling sets", A_PEND, 8'h08);
    wr(A_PEND, 8'h00);
    set_pins(8'hFF);
    expect_reg("R6 rising ignored", A_PEND, 8'h00);
  endtask

  task automatic t_disabled;
    wr(A_LO, 8'h00);
    wr(A_IEN, 8'h00);
    set_pins(8'hEF);
    expect_reg("R7 disabled pin", A_PEND, 8'h00);
    check("R7 irq stays high", {7'd0, irq_n}, 8'h01);
    set_pins(8'hFF);
  endtask

  task automatic t_output;
    wr(A_HI, 8'h0C);
    wr(A_IEN, 8'h20);
    check("R8 oe on pin5", pin_oe, 8'h20);
    set_pins(8'hDF);
    set_pins(8'hFF);
    expect_reg("R8 output mode silent", A_PEND, 8'h00);
    wr(A_HI, 8'h00);
  endtask

  task automatic t_race;
    wr(A_LO, 8'h04);
    wr(A_IEN, 8'h03);
    set_pins(8'hFE);
    expect_reg("R11 setup bit0", A_PEND, 8'h01);
    set_pins(8'hFC);
    expect_reg("R5 pin1 fall ignored", A_PEND, 8'h01);
    pin_in = 8'hFE;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    wr(A_PEND, 8'h00);
    expect_reg("R11 set beats clear", A_PEND, 8'h02);
    check("R11 irq low", {7'd0, irq_n}, 8'h00);
    wr(A_PEND, 8'h00);
    check("R9 irq released", {7'd0, irq_n}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    arst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = 8'h00; bus_wdata = 8'h00; pin_in = 8'hFF;
    tick(5);
    arst_n = 1'b1;
    tick(4);
    t_reset();
    t_data();
    t_ctrl();
    t_fall_and_clear();
    t_rise();
    t_pullup();
    t_disabled();
    t_output();
    t_race();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule